// File: doc/BRIEF.md
# Windowed Three-Port DDR Slot Arbiter

This block decides which of three requesters gets the next DDR command slot. The requesters are a hard-real-time DMA port, a soft-real-time DMA port and a CPU port. Time alternates between a DMA window and a CPU window. Each window has a programmable length in clock cycles. Within a window, requests of the favoured side are served back to back, so accesses of one kind stay grouped. A window ends in one of three ways: its count runs out, its side has nothing to ask, or a port on the other side set to always preempt raises a request.

Every grant is one DDR burst of four clock cycles. A CPU credit account grows by a programmable ratio for every CPU burst and drains by one per cycle. While the account is at or above a programmable limit, the CPU is held off. During that time, inside the CPU window, the soft-real-time DMA port takes the CPU's place. DDR timing, data movement and bank handling belong to other blocks.

Top module: `ddr_slot_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, all three grants are low, `cpu_hold` is low and `win_cpu` is high. The CPU window is current and counts as already expired.
- R2: The arbiter decides only when no burst is running or on the last cycle of a burst. A grant lasts exactly 4 cycles even if the request drops. At most one grant is high at a time. A grant rises only for a port that was requesting in the deciding cycle. Bursts may follow each other with no gap.
- R3: Inside the DMA window, the hard-real-time port wins over the soft-real-time port.
- R4: On each switch the new window is loaded with its length L. The window then admits ceil(L/4) bursts of its own side, and at least one, while the other side keeps requesting. After that the window switches. `win_cpu` is 1 for the CPU window and 0 for the DMA window, and it changes only at a deciding cycle.
- R5: If the current side has no eligible request at a decision and the other side has one, the window switches at once and the other side is granted.
- R6: If the other side has no request, an expired window does not switch. It keeps serving its own side, or idles.
- R7: A port whose 2-bit preemption field is 3 ends the other side's window at the next decision when that port requests. The CPU port can preempt only while it is not held.
- R8: Preemption field values 0, 1 and 2 never end the other side's window early.
- R9: Each CPU burst adds `cpu_ratio` to the account. The account drops by one every cycle while nonzero and saturates at both ends. `cpu_hold` is high while the account is at or above `cpu_limit`. The CPU is never granted while held, and it becomes eligible again once the account falls below the limit.
- R10: With `cpu_limit` at least 6 times `cpu_ratio` and an empty account, a CPU that requests continuously receives at least 6 back-to-back bursts. With ratio 8 and limit 48 it receives exactly 12.
- R11: While the CPU is held inside the CPU window, a pending soft-real-time request is granted in the CPU's slot and `win_cpu` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_hrt | input | 1 | Hard-real-time DMA request |
| req_srt | input | 1 | Soft-real-time DMA request |
| req_cpu | input | 1 | CPU request |
| dma_win_len | input | WIN_W | DMA window length in cycles |
| cpu_win_len | input | WIN_W | CPU window length in cycles |
| pre_hrt | input | 2 | Hard-real-time preemption field (3 = always) |
| pre_srt | input | 2 | Soft-real-time preemption field (3 = always) |
| pre_cpu | input | 2 | CPU preemption field (3 = always) |
| cpu_ratio | input | ACC_W | Account increment per CPU burst |
| cpu_limit | input | ACC_W | Account level at which the CPU is held |
| gnt_hrt | output | 1 | Hard-real-time burst grant |
| gnt_srt | output | 1 | Soft-real-time burst grant |
| gnt_cpu | output | 1 | CPU burst grant |
| win_cpu | output | 1 | 1 while the CPU window is current |
| cpu_hold | output | 1 | CPU account at or above its limit |

## Verification
A wrong window count shows up as a burst sequence that switches one burst early or late, at the first boundary where the count expires. A wrong side register shows up in `win_cpu` and in the grant at the very next decision. An account that drifts shows up in how many CPU bursts arrive before the first substituted soft-real-time burst, within a few dozen cycles of the CPU starting to request. A faulty burst timer shows up within one burst as a grant that is shorter or longer than four cycles.

// File: rtl/ddr_arb_pkg.sv
package ddr_arb_pkg;
  typedef enum logic {
    SIDE_DMA = 1'b0,
    SIDE_CPU = 1'b1
  } side_e;

  typedef struct packed {
    logic hrt;
    logic srt;
    logic cpu;
  } slot_t;

  localparam logic [1:0] PRE_ALWAYS = 2'b11;
endpackage

// File: rtl/arb_burst_timer.sv
module arb_burst_timer #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic free
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

  logic              busy;
  logic [BEAT_W-1:0] beat;

  assign free = !busy || (beat == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      beat <= '0;
    end else if (free) begin
      busy <= start;
      beat <= '0;
    end else begin
      beat <= beat + 1'b1;
    end
  end

  // R2: a started burst keeps the slot busy on the following cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (free && start) |=> (busy && !free || BURST_LEN == 1));

  p_beat_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> beat == '0);
endmodule

// File: rtl/arb_window_ctrl.sv
module arb_window_ctrl
  import ddr_arb_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             free,
  input  logic             flip,
  input  logic [WIN_W-1:0] dma_len,
  input  logic [WIN_W-1:0] cpu_len,
  output side_e            side,
  output logic             expired
);
  logic [WIN_W-1:0] left;
  logic [WIN_W-1:0] next_len;

  assign expired  = (left == '0);
  assign next_len = (side == SIDE_DMA) ? cpu_len : dma_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      side <= SIDE_CPU;
      left <= '0;
    end else if (free && flip) begin
      side <= (side == SIDE_DMA) ? SIDE_CPU : SIDE_DMA;
      left <= (next_len == '0) ? '0 : next_len - 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  // R4: the current window only changes at a deciding cycle
  p_side_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    !free |=> $stable(side));

  // R4: a window is never left while it still has cycles and no reason to switch
  p_no_spurious_flip_r4: assert property (@(posedge clk) disable iff (rst)
    (free && !flip) |=> $stable(side));
endmodule

// File: rtl/arb_cpu_credit.sv
module arb_cpu_credit #(
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_take,
  input  logic [ACC_W-1:0] ratio,
  input  logic [ACC_W-1:0] limit,
  output logic             blocked
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] drained;
  logic [ACC_W:0]   summed;

  assign blocked = (acc >= limit);
  assign drained = (acc == '0) ? '0 : acc - 1'b1;
  assign summed  = {1'b0, drained} + (cpu_take ? {1'b0, ratio} : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (summed[ACC_W]) begin
      acc <= '1;
    end else begin
      acc <= summed[ACC_W-1:0];
    end
  end

  // R9: the CPU is never picked while its account is at or over the limit
  p_take_needs_credit_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_take |-> !blocked);

  // R9: without CPU bursts the account never grows
  p_no_growth_r9: assert property (@(posedge clk) disable iff (rst)
    !cpu_take |=> acc <= $past(acc));
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import ddr_arb_pkg::*;
(
  input  logic       req_hrt,
  input  logic       req_srt,
  input  logic       req_cpu,
  input  logic [1:0] pre_hrt,
  input  logic [1:0] pre_srt,
  input  logic [1:0] pre_cpu,
  input  side_e      side,
  input  logic       expired,
  input  logic       blocked,
  output logic       flip,
  output slot_t      pick
);
  logic cpu_ok;
  logic dma_has;
  logic cpu_has;
  logic cur_has;
  logic oth_has;
  logic preempt;
  side_e eff;

  always_comb begin
    cpu_ok  = req_cpu && !blocked;
    dma_has = req_hrt || req_srt;
    cpu_has = cpu_ok || (blocked && req_srt);
    if (side == SIDE_CPU) begin
      cur_has = cpu_has;
      oth_has = dma_has;
      preempt = (req_hrt && pre_hrt == PRE_ALWAYS) ||
                (req_srt && pre_srt == PRE_ALWAYS);
    end else begin
      cur_has = dma_has;
      oth_has = cpu_has;
      preempt = cpu_ok && pre_cpu == PRE_ALWAYS;
    end
    flip = oth_has && (expired || !cur_has || preempt);
    eff  = flip ? ((side == SIDE_CPU) ? SIDE_DMA : SIDE_CPU) : side;
    pick = '0;
    if (eff == SIDE_DMA) begin
      if (req_hrt)      pick.hrt = 1'b1;
      else if (req_srt) pick.srt = 1'b1;
    end else begin
      if (cpu_ok)                  pick.cpu = 1'b1;
      else if (blocked && req_srt) pick.srt = 1'b1;
    end
  end
endmodule

// File: rtl/ddr_slot_arbiter.sv
module ddr_slot_arbiter
  import ddr_arb_pkg::*;
#(
  parameter int WIN_W     = 8,
  parameter int ACC_W     = 10,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_hrt,
  input  logic             req_srt,
  input  logic             req_cpu,
  input  logic [WIN_W-1:0] dma_win_len,
  input  logic [WIN_W-1:0] cpu_win_len,
  input  logic [1:0]       pre_hrt,
  input  logic [1:0]       pre_srt,
  input  logic [1:0]       pre_cpu,
  input  logic [ACC_W-1:0] cpu_ratio,
  input  logic [ACC_W-1:0] cpu_limit,
  output logic             gnt_hrt,
  output logic             gnt_srt,
  output logic             gnt_cpu,
  output logic             win_cpu,
  output logic             cpu_hold
);
  side_e side;
  logic  expired;
  logic  blocked;
  logic  free;
  logic  flip;
  slot_t pick;
  slot_t gnt_q;

  arb_burst_timer #(.BURST_LEN(BURST_LEN)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (pick != '0),
    .free  (free)
  );

  arb_window_ctrl #(.WIN_W(WIN_W)) u_window (
    .clk     (clk),
    .rst     (rst),
    .free    (free),
    .flip    (flip),
    .dma_len (dma_win_len),
    .cpu_len (cpu_win_len),
    .side    (side),
    .expired (expired)
  );

  arb_cpu_credit #(.ACC_W(ACC_W)) u_credit (
    .clk      (clk),
    .rst      (rst),
    .cpu_take (free && pick.cpu),
    .ratio    (cpu_ratio),
    .limit    (cpu_limit),
    .blocked  (blocked)
  );

  arb_pick u_pick (
    .req_hrt (req_hrt),
    .req_srt (req_srt),
    .req_cpu (req_cpu),
    .pre_hrt (pre_hrt),
    .pre_srt (pre_srt),
    .pre_cpu (pre_cpu),
    .side    (side),
    .expired (expired),
    .blocked (blocked),
    .flip    (flip),
    .pick    (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
    end else if (free) begin
      gnt_q <= pick;
    end
  end

  assign gnt_hrt  = gnt_q.hrt;
  assign gnt_srt  = gnt_q.srt;
  assign gnt_cpu  = gnt_q.cpu;
  assign win_cpu  = (side == SIDE_CPU);
  assign cpu_hold = blocked;

  // R2: never more than one grant
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  // R2: a running burst keeps its grant
  p_burst_held_r2: assert property (@(posedge clk) disable iff (rst)
    (!free && gnt_q != '0) |=> $stable(gnt_q));

  // R2: a grant rises only for a port that was asking
  p_hrt_asked_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_hrt) |-> $past(req_hrt));
  p_cpu_asked_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_cpu) |-> $past(req_cpu));

  // R3: soft-real-time wins a DMA window only when hard-real-time is idle
  p_dma_priority_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(gnt_srt) && !win_cpu) |-> !$past(req_hrt));
endmodule

// File: tb/test_ddr_slot_arbiter.sv
module test_ddr_slot_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_hrt = 1'b0, req_srt = 1'b0, req_cpu = 1'b0;
  logic [7:0] dma_win_len = 8'd64, cpu_win_len = 8'd64;
  logic [1:0] pre_hrt = 2'd0, pre_srt = 2'd0, pre_cpu = 2'd0;
  logic [9:0] cpu_ratio = 10'd8, cpu_limit = 10'd48;
  logic       gnt_hrt, gnt_srt, gnt_cpu, win_cpu, cpu_hold;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [2:0] H = 3'b100, S = 3'b010, C = 3'b001, N = 3'b000;

  // {req_hrt,req_srt,req_cpu, expected grant hrt/srt/cpu, expected win_cpu}
  localparam logic [6:0] VEC [0:7] = '{
    7'b111_100_0, 7'b011_010_0, 7'b001_001_1, 7'b100_100_0,
    7'b000_000_1, 7'b010_010_0, 7'b101_100_0, 7'b110_100_0
  };

  localparam logic [2:0] WSEQ [0:7] = '{H, H, C, C, C, H, H, C};

  always #2 clk = ~clk;

  ddr_slot_arbiter i_ddr_slot_arbiter (
    .clk (clk), .rst (rst),
    .req_hrt (req_hrt), .req_srt (req_srt), .req_cpu (req_cpu),
    .dma_win_len (dma_win_len), .cpu_win_len (cpu_win_len),
    .pre_hrt (pre_hrt), .pre_srt (pre_srt), .pre_cpu (pre_cpu),
    .cpu_ratio (cpu_ratio), .cpu_limit (cpu_limit),
    .gnt_hrt (gnt_hrt), .gnt_srt (gnt_srt), .gnt_cpu (gnt_cpu),
    .win_cpu (win_cpu), .cpu_hold (cpu_hold)
  );

  function automatic logic [2:0] g3();
    return {gnt_hrt, gnt_srt, gnt_cpu};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {req_hrt, req_srt, req_cpu} = 3'b000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic next_burst();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int cnt;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 grants in reset", g3(), N);
    chk("R1 win_cpu in reset", win_cpu, 1);
    chk("R1 cpu_hold in reset", cpu_hold, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grants after reset idle", g3(), N);

    // R3 R5 R6: first decision after reset under each request pattern
    for (int i = 0; i < 8; i++) begin
      do_reset();
      {req_hrt, req_srt, req_cpu} = VEC[i][6:4];
      @(negedge clk);
      chk($sformatf("R3/R5/R6 vector %0d grant", i), g3(), VEC[i][3:1]);
      chk($sformatf("R4 vector %0d win_cpu", i), win_cpu, VEC[i][0]);
    end

    // R2: a one-cycle request still gets a full 4-cycle burst
    do_reset();
    req_srt = 1'b1;
    @(negedge clk);
    req_srt = 1'b0;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      if (gnt_srt) cnt++;
      @(negedge clk);
    end
    chk("R2 burst length", cnt, 4);
    chk("R2 idle after burst", g3(), N);

    // R4: windows of 8 and 12 cycles give 2 and 3 bursts
    dma_win_len = 8'd8;
    cpu_win_len = 8'd12;
    do_reset();
    {req_hrt, req_cpu} = 2'b11;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R4 window burst %0d", i), g3(), WSEQ[i]);
      chk($sformatf("R4 window flag %0d", i), win_cpu, WSEQ[i] == C);
      next_burst();
    end

    // R5: empty DMA window hands over to the CPU at once
    dma_win_len = 8'd64;
    cpu_win_len = 8'd64;
    do_reset();
    {req_hrt, req_cpu} = 2'b11;
    @(negedge clk);
    chk("R5 first burst", g3(), H);
    next_burst();
    chk("R6 long window second burst", g3(), H);
    req_hrt = 1'b0;
    next_burst();
    chk("R5 switch on empty window", g3(), C);
    chk("R5 window flag", win_cpu, 1);

    // R8: preemption field 2 does not cut the CPU window
    dma_win_len = 8'd4;
    pre_hrt = 2'd2;
    do_reset();
    {req_hrt, req_cpu} = 2'b11;
    @(negedge clk);
    chk("R4 short DMA window", g3(), H);
    for (int i = 0; i < 3; i++) begin
      next_burst();
      chk($sformatf("R8 mode 2 no preempt %0d", i), g3(), C);
    end
    // R7: field 3 preempts at the next decision
    pre_hrt = 2'd3;
    next_burst();
    chk("R7 hrt preempts CPU window", g3(), H);
    chk("R7 window flag", win_cpu, 0);
    pre_hrt = 2'd0;

    // R7: CPU with field 3 cuts a long DMA window
    dma_win_len = 8'd64;
    pre_cpu = 2'd3;
    do_reset();
    {req_hrt, req_cpu} = 2'b11;
    @(negedge clk);
    chk("R7 cpu preempt first", g3(), H);
    next_burst();
    chk("R7 cpu preempts DMA window", g3(), C);
    // R8: field 1 does not
    pre_cpu = 2'd1;
    do_reset();
    {req_hrt, req_cpu} = 2'b11;
    @(negedge clk);
    next_burst();
    chk("R8 mode 1 no preempt", g3(), H);
    pre_cpu = 2'd0;

    // R9 R10 R11: CPU account blocks a bursty CPU
    dma_win_len = 8'd1;
    cpu_win_len = 8'd255;
    do_reset();
    {req_srt, req_cpu} = 2'b11;
    @(negedge clk);
    chk("R11 first burst to srt", g3(), S);
    chk("R9 hold clear at start", cpu_hold, 0);
    next_burst();
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      if (g3() != C) break;
      cnt++;
      next_burst();
    end
    chk("R10 at least six CPU bursts", cnt >= 6, 1);
    chk("R9 exact CPU run before hold", cnt, 12);
    chk("R11 srt fills CPU slot", g3(), S);
    chk("R11 CPU window kept", win_cpu, 1);
    chk("R9 hold high while blocked", cpu_hold, 1);
    next_burst();
    chk("R9 CPU eligible again", g3(), C);
    {req_srt, req_cpu} = 2'b00;
    repeat (80) @(negedge clk);
    chk("R9 account drains", cpu_hold, 0);

    done = 1'b1;
    finish_run();
  end
endmodule